// File: doc/BRIEF.md
# Windowed Software Watchdog

This block is a down-counting watchdog that a processor must service on schedule. After reset it runs with no software setup, starting from a built-in timeout value and counting one step for each pulse of the selected tick input. Software keeps it from expiring by writing a two-word key sequence to a service register. The counter then reloads from the programmable timeout. If the count runs out, the block requests a system reset, or in interrupt mode it first raises an interrupt and gives software one more period.

A window option makes servicing too early a fault. While the count is still at or above a programmable window value, any service key write causes the timeout action at once. The counting source is one of two tick enables, one standing for the system clock and one for a crystal clock. The control, timeout and window registers can be protected by a soft lock, which a separate two-word unlock sequence releases. They can also be protected by a hard lock, which only a reset clears.

Top module: `swdog_top`

## Requirements
- R1: After reset, CTRL (address 0) reads 0x01 (enabled, system tick, reset mode, no window, unlocked), COUNT (address 4) reads the default timeout, and irq_o and rst_req_o are low.
- R2: While enabled, the counter decrements by one on each pulse of the tick selected by CTRL bit 1 (0 = tick_sys_i, 1 = tick_xtal_i). Pulses on the other tick input leave it unchanged.
- R3: With CTRL bit 2 = 0, a selected tick while the count is 0 raises rst_req_o and reloads the counter from TIMEOUT (address 1). rst_req_o then stays high until reset.
- R4: With CTRL bit 2 = 1, the first timeout sets irq_o (STATUS bit 0) and reloads the counter. A timeout while irq_o is still set raises rst_req_o. Writing 1 to STATUS bit 0 (address 5) clears irq_o.
- R5: Writing 0xA602 and then 0xB480 (low 16 bits) to SERVICE (address 3) reloads the counter from TIMEOUT. A lone 0xB480 does nothing. Any other value in between restarts the sequence.
- R6: With CTRL bit 3 = 1, a service key write (0xA602 or 0xB480) while the count is at or above WINDOW (address 2) triggers the timeout action at once. Once the count is below WINDOW, the sequence reloads normally.
- R7: While CTRL bit 4 (soft lock) is set, writes to CTRL, TIMEOUT and WINDOW are ignored and set STATUS bit 1. Writing 1 to STATUS bit 1 clears that flag. Writing 0xC520 and then 0xD928 to SERVICE clears the soft lock.
- R8: CTRL bit 5 (hard lock) is write-once. Neither a CTRL write nor the unlock sequence clears it, and while it is set the configuration registers ignore writes.
- R9: A read strobe at one clock edge presents the addressed register on rdata_o from that edge onward. COUNT returns the live count and CTRL returns bits 5:0.
- R10: With CTRL bit 0 = 0, the counter holds its value whatever the tick inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_sys_i | input | 1 | Count enable from the system clock domain |
| tick_xtal_i | input | 1 | Count enable from the crystal clock domain |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Sticky interrupt request |
| rst_req_o | output | 1 | Sticky reset request |

## Verification
A corrupted count shows up one read later as a wrong COUNT value. It also shows as a timeout that comes one tick early or late, seen on irq_o or rst_req_o right after the tick that should or should not expire. A key-sequence state that is stuck or reset wrongly shows as a COUNT that fails to reload, or reloads when it should not, right after the second key word. A lock bit held wrongly shows on the next readback of the register it guards and in STATUS bit 1.

// File: rtl/swdog_pkg.sv
package swdog_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_CTRL    = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_TIMEOUT = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_WINDOW  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_SERVICE = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_COUNT   = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_STATUS  = 3'd5;

    localparam logic [15:0] KEY_SVC_A = 16'hA602;
    localparam logic [15:0] KEY_SVC_B = 16'hB480;
    localparam logic [15:0] KEY_UNL_A = 16'hC520;
    localparam logic [15:0] KEY_UNL_B = 16'hD928;

    // Bit layout matches the CTRL register, LSB = enable.
    typedef struct packed {
        logic hard_lock;
        logic soft_lock;
        logic win_en;
        logic irq_mode;
        logic clk_sel;
        logic enable;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_SVC1,
        SEQ_UNL1
    } seq_e;

endpackage

// File: rtl/swdog_keyseq.sv
module swdog_keyseq
    import swdog_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        svc_wr_i,
    input  logic [15:0] key_i,
    output logic        svc_ok_o,
    output logic        unlock_o,
    output logic        key_wr_o
);

    typedef struct packed {
        seq_e st;
    } seq_state_t;

    seq_state_t s_q, s_d;

    always_comb begin
        s_d      = s_q;
        svc_ok_o = 1'b0;
        unlock_o = 1'b0;
        key_wr_o = svc_wr_i && (key_i == KEY_SVC_A || key_i == KEY_SVC_B);
        if (svc_wr_i) begin
            if (key_i == KEY_SVC_A) begin
                s_d.st = SEQ_SVC1;
            end else if (key_i == KEY_UNL_A) begin
                s_d.st = SEQ_UNL1;
            end else if (key_i == KEY_SVC_B && s_q.st == SEQ_SVC1) begin
                s_d.st   = SEQ_IDLE;
                svc_ok_o = 1'b1;
            end else if (key_i == KEY_UNL_B && s_q.st == SEQ_UNL1) begin
                s_d.st   = SEQ_IDLE;
                unlock_o = 1'b1;
            end else begin
                s_d.st = SEQ_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SEQ_IDLE};
        else        s_q <= s_d;
    end

    AST_SEQ_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_wr_i && key_i != KEY_SVC_A && key_i != KEY_SVC_B &&
         key_i != KEY_UNL_A && key_i != KEY_UNL_B) |=> (s_q.st == SEQ_IDLE)); // R5

endmodule

// File: rtl/swdog_cfg.sv
module swdog_cfg
    import swdog_pkg::*;
#(
    parameter int          DATA_W      = 32,
    parameter int          CNT_W       = 32,
    parameter logic [31:0] DEF_TIMEOUT = 32'h000F_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              unlock_i,
    output ctrl_t             ctrl_o,
    output logic [CNT_W-1:0]  timeout_o,
    output logic [CNT_W-1:0]  window_o,
    output logic              acc_err_o
);

    localparam logic [CNT_W-1:0] TIMEOUT_RST = CNT_W'(DEF_TIMEOUT);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] timeout;
        logic [CNT_W-1:0] window;
        logic             err;
    } cfg_state_t;

    cfg_state_t s_q, s_d;
    logic       locked;
    logic       cfg_wr;
    ctrl_t      wr_ctrl;

    assign locked  = s_q.ctrl.soft_lock | s_q.ctrl.hard_lock;
    assign cfg_wr  = wr_en_i && (addr_i == ADR_CTRL || addr_i == ADR_TIMEOUT ||
                                 addr_i == ADR_WINDOW);
    assign wr_ctrl = ctrl_t'(wdata_i[CTRL_W-1:0]);

    always_comb begin
        s_d = s_q;
        if (cfg_wr && locked) begin
            s_d.err = 1'b1;
        end else if (cfg_wr) begin
            unique case (addr_i)
                ADR_CTRL: begin
                    s_d.ctrl           = wr_ctrl;
                    s_d.ctrl.hard_lock = s_q.ctrl.hard_lock | wr_ctrl.hard_lock;
                end
                ADR_TIMEOUT: s_d.timeout = wdata_i[CNT_W-1:0];
                default:     s_d.window  = wdata_i[CNT_W-1:0];
            endcase
        end
        if (wr_en_i && addr_i == ADR_STATUS && wdata_i[1]) begin
            s_d.err = 1'b0;
        end
        if (unlock_i) begin
            s_d.ctrl.soft_lock = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ctrl        <= '{enable: 1'b1, default: 1'b0};
            s_q.timeout     <= TIMEOUT_RST;
            s_q.window      <= '0;
            s_q.err         <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl_o    = s_q.ctrl;
    assign timeout_o = s_q.timeout;
    assign window_o  = s_q.window;
    assign acc_err_o = s_q.err;

    AST_HARD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ctrl.hard_lock |=> s_q.ctrl.hard_lock); // R8

    AST_LOCK_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && locked) |=> ($stable(s_q.ctrl) && $stable(s_q.timeout) &&
                               $stable(s_q.window) && s_q.err)); // R7

endmodule

// File: rtl/swdog_core.sv
module swdog_core
    import swdog_pkg::*;
#(
    parameter int          CNT_W       = 32,
    parameter logic [31:0] DEF_TIMEOUT = 32'h000F_FFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_sys_i,
    input  logic             tick_xtal_i,
    input  ctrl_t            ctrl_i,
    input  logic [CNT_W-1:0] timeout_i,
    input  logic [CNT_W-1:0] window_i,
    input  logic             svc_ok_i,
    input  logic             key_wr_i,
    input  logic             clr_irq_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             irq_o,
    output logic             rst_req_o
);

    localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(DEF_TIMEOUT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
        logic             rst;
    } core_state_t;

    core_state_t s_q, s_d;
    logic        tick;
    logic        early;
    logic        fire;
    logic        reload;

    always_comb begin
        s_d    = s_q;
        fire   = 1'b0;
        reload = 1'b0;
        tick   = ctrl_i.enable & (ctrl_i.clk_sel ? tick_xtal_i : tick_sys_i);
        early  = ctrl_i.enable & ctrl_i.win_en & key_wr_i & (s_q.cnt >= window_i);

        if (clr_irq_i) s_d.irq = 1'b0;

        if (early) begin
            fire = 1'b1;
        end else if (svc_ok_i) begin
            reload = 1'b1;
        end else if (tick) begin
            if (s_q.cnt == '0) fire = 1'b1;
            else               s_d.cnt = s_q.cnt - 1'b1;
        end

        if (fire) begin
            reload = 1'b1;
            if (ctrl_i.irq_mode && !s_q.irq) s_d.irq = 1'b1;
            else                             s_d.rst = 1'b1;
        end
        if (reload) s_d.cnt = timeout_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt <= CNT_RST;
            s_q.irq <= 1'b0;
            s_q.rst <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o     = s_q.cnt;
    assign irq_o     = s_q.irq;
    assign rst_req_o = s_q.rst;

    AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rst |=> s_q.rst); // R3

    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_i.enable && !svc_ok_i) |=> $stable(s_q.cnt)); // R10

    AST_SVC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        svc_ok_i |=> (s_q.cnt == $past(timeout_i))); // R5

    AST_IRQ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(s_q.rst) && $past(ctrl_i.irq_mode)) |-> $past(s_q.irq)); // R4

    AST_WIN_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i.enable && ctrl_i.win_en && key_wr_i && s_q.cnt >= window_i &&
         !ctrl_i.irq_mode) |=> s_q.rst); // R6

endmodule

// File: rtl/swdog_top.sv
module swdog_top
    import swdog_pkg::*;
#(
    parameter int          DATA_W      = 32,
    parameter int          CNT_W       = 32,
    parameter logic [31:0] DEF_TIMEOUT = 32'h000F_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_sys_i,
    input  logic              tick_xtal_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o,
    output logic              rst_req_o
);

    ctrl_t             ctrl;
    logic [CNT_W-1:0]  timeout;
    logic [CNT_W-1:0]  window;
    logic [CNT_W-1:0]  cnt;
    logic              acc_err;
    logic              svc_ok;
    logic              unlock;
    logic              key_wr;
    logic              svc_wr;
    logic              clr_irq;
    logic [DATA_W-1:0] rd_d, rd_q;

    assign svc_wr  = wr_en_i && addr_i == ADR_SERVICE;
    assign clr_irq = wr_en_i && addr_i == ADR_STATUS && wdata_i[0];

    swdog_keyseq u_keyseq (
        .clk      (clk),
        .rst_n    (rst_n),
        .svc_wr_i (svc_wr),
        .key_i    (wdata_i[15:0]),
        .svc_ok_o (svc_ok),
        .unlock_o (unlock),
        .key_wr_o (key_wr)
    );

    swdog_cfg #(
        .DATA_W      (DATA_W),
        .CNT_W       (CNT_W),
        .DEF_TIMEOUT (DEF_TIMEOUT)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .unlock_i  (unlock),
        .ctrl_o    (ctrl),
        .timeout_o (timeout),
        .window_o  (window),
        .acc_err_o (acc_err)
    );

    swdog_core #(
        .CNT_W       (CNT_W),
        .DEF_TIMEOUT (DEF_TIMEOUT)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_sys_i  (tick_sys_i),
        .tick_xtal_i (tick_xtal_i),
        .ctrl_i      (ctrl),
        .timeout_i   (timeout),
        .window_i    (window),
        .svc_ok_i    (svc_ok),
        .key_wr_i    (key_wr),
        .clr_irq_i   (clr_irq),
        .cnt_o       (cnt),
        .irq_o       (irq_o),
        .rst_req_o   (rst_req_o)
    );

    always_comb begin
        rd_d = rd_q;
        if (rd_en_i) begin
            case (addr_i)
                ADR_CTRL:    rd_d = DATA_W'(ctrl);
                ADR_TIMEOUT: rd_d = DATA_W'(timeout);
                ADR_WINDOW:  rd_d = DATA_W'(window);
                ADR_COUNT:   rd_d = DATA_W'(cnt);
                ADR_STATUS:  rd_d = DATA_W'({acc_err, irq_o});
                default:     rd_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata_o = rd_q;

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rdata_o)); // R9

endmodule

// File: tb/swdog_top_bench.sv
`timescale 1ns/1ps
module swdog_top_bench;

    localparam int DEF_TO = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_sys = 1'b0;
    logic        tick_xtal = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic        rst_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];
    logic  rd_seen = 1'b0;

    always #4 clk = ~clk;

    swdog_top #(.DEF_TIMEOUT(DEF_TO)) u_swdog_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_sys_i  (tick_sys),
        .tick_xtal_i (tick_xtal),
        .wr_en_i     (wr_en),
        .rd_en_i     (rd_en),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .rdata_o     (rdata),
        .irq_o       (irq),
        .rst_req_o   (rst_req)
    );

    // Monitor: compares each read result against the queued expectation.
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (rdata !== it.exp) begin
                n_fail++;
                $display("FAIL %s: read got %h expected %h", it.tag, rdata, it.exp);
            end
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: pin got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic tick(input bit xtal, input int n);
        for (int i = 0; i < n; i++) begin
            if (xtal) tick_xtal = 1'b1; else tick_sys = 1'b1;
            @(negedge clk);
            tick_xtal = 1'b0; tick_sys = 1'b0;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic service();
        wr(3'd3, 32'hA602);
        wr(3'd3, 32'hB480);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        rd(3'd0, 32'h01, "R1 ctrl");
        rd(3'd4, DEF_TO, "R1 count");
        chk(rst_req, 1'b0, "R1 rst_req");
        chk(irq, 1'b0, "R1 irq");

        // R2 tick selection
        tick(0, 3);
        rd(3'd4, DEF_TO - 3, "R2 sys tick");
        tick(1, 2);
        rd(3'd4, DEF_TO - 3, "R2 xtal ignored");
        wr(3'd0, 32'h03);
        tick(1, 2);
        tick(0, 1);
        rd(3'd4, DEF_TO - 5, "R2 xtal selected");
        rd(3'd0, 32'h03, "R9 ctrl readback");

        // R10 disabled holds
        wr(3'd0, 32'h02);
        tick(1, 5);
        rd(3'd4, DEF_TO - 5, "R10 hold");

        // R5 service sequence
        wr(3'd0, 32'h01);
        wr(3'd3, 32'hB480);
        rd(3'd4, DEF_TO - 5, "R5 lone second key");
        wr(3'd3, 32'hA602);
        wr(3'd3, 32'h1234);
        wr(3'd3, 32'hB480);
        rd(3'd4, DEF_TO - 5, "R5 broken sequence");
        service();
        rd(3'd4, DEF_TO, "R5 reload");

        // R4 interrupt mode
        wr(3'd1, 32'd5);
        service();
        wr(3'd0, 32'h05);
        tick(0, 5);
        chk(irq, 1'b0, "R4 no irq at zero");
        tick(0, 1);
        chk(irq, 1'b1, "R4 first timeout irq");
        chk(rst_req, 1'b0, "R4 no reset yet");
        rd(3'd4, 32'd5, "R4 reload");
        rd(3'd5, 32'h1, "R4 status irq");
        tick(0, 6);
        chk(rst_req, 1'b1, "R4 second timeout reset");
        do_reset();

        // R3 reset mode
        wr(3'd1, 32'd3);
        service();
        tick(0, 3);
        chk(rst_req, 1'b0, "R3 not before zero tick");
        tick(0, 1);
        chk(rst_req, 1'b1, "R3 timeout reset");
        rd(3'd4, 32'd3, "R3 reload");
        tick(0, 2);
        chk(rst_req, 1'b1, "R3 sticky");
        do_reset();
        chk(rst_req, 1'b0, "R1 reset clears request");

        // R4 irq clear
        wr(3'd1, 32'd2);
        service();
        wr(3'd0, 32'h05);
        tick(0, 3);
        chk(irq, 1'b1, "R4 irq set");
        wr(3'd5, 32'h1);
        chk(irq, 1'b0, "R4 irq cleared");
        tick(0, 3);
        chk(irq, 1'b1, "R4 irq again");
        chk(rst_req, 1'b0, "R4 cleared avoids reset");
        do_reset();

        // R6 window mode
        wr(3'd2, 32'd10);
        wr(3'd0, 32'h09);
        wr(3'd3, 32'hA602);
        chk(rst_req, 1'b1, "R6 early key");
        do_reset();
        wr(3'd2, 32'd10);
        wr(3'd0, 32'h09);
        tick(0, DEF_TO - 5);
        service();
        chk(rst_req, 1'b0, "R6 in-window no reset");
        rd(3'd4, DEF_TO, "R6 in-window reload");

        // R7 soft lock
        do_reset();
        wr(3'd0, 32'h11);
        rd(3'd0, 32'h11, "R7 lock set");
        wr(3'd1, 32'd7);
        rd(3'd1, DEF_TO, "R7 timeout ignored");
        rd(3'd5, 32'h2, "R7 error flag");
        wr(3'd0, 32'h00);
        rd(3'd0, 32'h11, "R7 ctrl ignored");
        wr(3'd3, 32'hC520);
        wr(3'd3, 32'hD928);
        rd(3'd0, 32'h01, "R7 unlocked");
        wr(3'd1, 32'd7);
        rd(3'd1, 32'd7, "R7 write after unlock");
        wr(3'd5, 32'h2);
        rd(3'd5, 32'h0, "R7 error cleared");

        // R8 hard lock
        wr(3'd0, 32'h21);
        rd(3'd0, 32'h21, "R8 hard set");
        wr(3'd0, 32'h00);
        rd(3'd0, 32'h21, "R8 ctrl write ignored");
        wr(3'd3, 32'hC520);
        wr(3'd3, 32'hD928);
        wr(3'd2, 32'd3);
        rd(3'd0, 32'h21, "R8 unlock ignored");
        rd(3'd2, 32'd0, "R8 window ignored");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule